// File: doc/BRIEF.md
# Binary Seconds Counter with Prescaler

This block keeps elapsed time as a 32-bit binary count of seconds. A 32.768 kHz tick enable drives a 15-bit prescaler; each time the prescaler wraps, the seconds count advances by one. Software can load the count one byte at a time. A write to the lowest byte also clears the prescaler, so the next second falls a full 32768 ticks after that write.

Reads never see the live count directly. A snapshot strobe copies the live count into a held read value. The read value then stays fixed while counting goes on. The system pulses the strobe at the start of each read transaction, so a multi-byte read is coherent.

A square-wave output runs at one of four rates tapped from the prescaler. A sticky stop flag records that the oscillator was disabled or was reported stopped, and it stays set until software clears it. An oscillator-disable control freezes the prescaler and the count and holds the square wave low. An external stop-detect input stands in for detecting a real oscillator failure.

Top module: `secs_counter_top`

## Requirements
- R1: After reset, rd_value is 0, sqw is 0 and stop_flag is 1.
- R2: With osc_off low and tick_en high, the seconds count rises by exactly 1 on the 32768th tick after the prescaler was last cleared, and at no other time.
- R3: While osc_off is 1, tick_en is ignored: the prescaler and the seconds count keep their values.
- R4: A write with wr_addr = k (k = 0..3) replaces bits [8k+7:8k] of the live count with wr_data in the cycle of the strobe, and leaves the other three bytes unchanged.
- R5: A write to wr_addr = 0 clears the prescaler to 0 and suppresses any increment in that cycle.
- R6: When snap is 1, rd_value takes the live count on that clock edge. At all other times rd_value holds its value while the count keeps running.
- R7: sqw is registered from the prescaler state of the previous cycle. rate_sel 00 gives prescaler bit 14 (1 Hz), 01 gives bit 2 (4.096 kHz) and 10 gives bit 1 (8.192 kHz). 11 gives tick_en itself, the 32.768 kHz base.
- R8: sqw is 0 in the cycle after any cycle in which osc_off is 1.
- R9: stop_flag is set on the edge after osc_off or stop_det is 1. flag_clr clears it only when neither of those is 1, so setting wins over clearing. Otherwise the flag keeps its value.
- R10: The seconds count wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | 32.768 kHz base tick enable, one clock wide |
| osc_off | input | 1 | 1 stops the oscillator (prescaler and count frozen) |
| stop_det | input | 1 | External oscillator-stop indication |
| flag_clr | input | 1 | Software write of 0 to the stop flag |
| rate_sel | input | 2 | Square-wave rate select |
| wr_en | input | 1 | Byte write strobe to the live count |
| wr_addr | input | 2 | Byte lane of the write, 0 is least significant |
| wr_data | input | 8 | Byte written |
| snap | input | 1 | Snapshot strobe |
| rd_value | output | 32 | Held snapshot of the count |
| sqw | output | 1 | Square-wave output |
| stop_flag | output | 1 | Sticky oscillator-stop flag |

## Verification
The assertions assume that tick_en is a one-cycle enable. They also assume that software writes and snapshots are single-cycle strobes that can coincide with ticks, and that rate_sel may change in any cycle. The bench drives every input only on the falling edge and keeps rst_n low long enough for the synchronized reset to settle. It lets writes, snapshots, ticks and oscillator-disable overlap, so the set-over-clear and clear-over-increment priorities are exercised. A behavioural model built on integer arithmetic is compared against rd_value, sqw and stop_flag on every clock.

// File: rtl/secs_pkg.sv
package secs_pkg;
  typedef enum logic [1:0] {
    RATE_1HZ  = 2'b00,
    RATE_4K   = 2'b01,
    RATE_8K   = 2'b10,
    RATE_BASE = 2'b11
  } rate_e;
endpackage

// File: rtl/secs_prescaler.sv
module secs_prescaler
  import secs_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             tick_en,
  input  logic             osc_off,
  input  logic             div_clr,
  input  logic [1:0]       rate_sel,
  output logic             sec_pulse,
  output logic [DIV_W-1:0] div_q,
  output logic             sqw_q
);
  localparam int TAP_SLOW = DIV_W - 1;
  localparam int TAP_4K   = 2;
  localparam int TAP_8K   = 1;

  logic             tick_run;
  logic             div_ce;
  logic [DIV_W-1:0] div_d;
  logic             tap;
  logic             sqw_d;

  always_comb begin
    tick_run  = tick_en & ~osc_off;
    div_ce    = div_clr | tick_run;
    div_d     = div_clr ? '0 : div_q + DIV_W'(1);
    sec_pulse = tick_run & (&div_q) & ~div_clr;
    unique case (rate_e'(rate_sel))
      RATE_1HZ: tap = div_q[TAP_SLOW];
      RATE_4K:  tap = div_q[TAP_4K];
      RATE_8K:  tap = div_q[TAP_8K];
      default:  tap = tick_en;
    endcase
    sqw_d = ~osc_off & tap;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      div_q <= '0;
    end else if (div_ce) begin
      div_q <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sqw_q <= 1'b0;
    end else begin
      sqw_q <= sqw_d;
    end
  end
endmodule

// File: rtl/secs_lane_counter.sv
module secs_lane_counter #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              sec_pulse,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam int NLANES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] inc_val;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    inc_val = cnt_q + CNT_W'(sec_pulse);
    cnt_ce  = sec_pulse | wr_en;
  end

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    always_comb begin
      if (wr_en && (wr_addr == ADDR_W'(k))) begin
        cnt_d[k*BYTE_W +: BYTE_W] = wr_data;
      end else begin
        cnt_d[k*BYTE_W +: BYTE_W] = inc_val[k*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/secs_stop_flag.sv
module secs_stop_flag (
  input  logic clk,
  input  logic rst_sn,
  input  logic osc_off,
  input  logic stop_det,
  input  logic flag_clr,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    if (osc_off || stop_det) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flag_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/secs_counter_top.sv
module secs_counter_top #(
  parameter int DIV_W  = 15,
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = $clog2(CNT_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              osc_off,
  input  logic              stop_det,
  input  logic              flag_clr,
  input  logic [1:0]        rate_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              snap,
  output logic [CNT_W-1:0]  rd_value,
  output logic              sqw,
  output logic              stop_flag
);
  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic             div_clr;
  logic             sec_pulse;
  logic [DIV_W-1:0] div_val;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn  = rst_pipe[1];
  assign div_clr = wr_en && (wr_addr == '0);

  secs_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .tick_en   (tick_en),
    .osc_off   (osc_off),
    .div_clr   (div_clr),
    .rate_sel  (rate_sel),
    .sec_pulse (sec_pulse),
    .div_q     (div_val),
    .sqw_q     (sqw)
  );

  secs_lane_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cnt (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .sec_pulse (sec_pulse),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cnt_q     (cnt_val)
  );

  secs_stop_flag u_flag (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .osc_off  (osc_off),
    .stop_det (stop_det),
    .flag_clr (flag_clr),
    .flag_q   (stop_flag)
  );

  always_comb begin
    rd_d = snap ? cnt_val : rd_value;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_value <= '0;
    end else begin
      rd_value <= rd_d;
    end
  end
endmodule

// File: rtl/secs_counter_chk.sv
module secs_counter_chk #(
  parameter int DIV_W  = 15,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              tick_en,
  input logic              osc_off,
  input logic              stop_det,
  input logic              flag_clr,
  input logic [1:0]        rate_sel,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              snap,
  input logic [DIV_W-1:0]  div_val,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [CNT_W-1:0]  rd_value,
  input logic              sqw,
  input logic              stop_flag
);
  // R3
  freeze_div_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (osc_off && !(wr_en && wr_addr == '0)) |=> $stable(div_val));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_en && !(tick_en && !osc_off && div_val == '1)) |=> $stable(cnt_val));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_en && tick_en && !osc_off && div_val == '1)
      |=> cnt_val == $past(cnt_val) + CNT_W'(1));

  // R5
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && wr_addr == '0) |=> div_val == '0);

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !snap |=> $stable(rd_value));

  // R6
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    snap |=> rd_value == $past(cnt_val));

  // R7
  sqw_4k_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!osc_off && rate_sel == 2'b01) |=> sqw == $past(div_val[2]));

  // R8
  sqw_off_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    osc_off |=> !sqw);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (osc_off || stop_det) |=> stop_flag);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (stop_flag && !flag_clr) |=> stop_flag);
endmodule

bind secs_counter_top secs_counter_chk #(
  .DIV_W(DIV_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/secs_counter_top_test.sv
module secs_counter_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_TOP    = 32768;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        osc_off = 1'b0;
  logic        stop_det = 1'b0;
  logic        flag_clr = 1'b0;
  logic [1:0]  rate_sel = 2'b00;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'b00;
  logic [7:0]  wr_data = 8'h00;
  logic        snap = 1'b0;
  logic [31:0] rd_value;
  logic        sqw;
  logic        stop_flag;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  secs_counter_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_off(osc_off),
    .stop_det(stop_det), .flag_clr(flag_clr), .rate_sel(rate_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .snap(snap),
    .rd_value(rd_value), .sqw(sqw), .stop_flag(stop_flag)
  );

  // Behavioural reference model
  int          m_div;
  logic [31:0] m_cnt;
  logic [31:0] m_rd;
  logic        m_sqw;
  logic        m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_rd = 0; m_sqw = 0; m_flag = 1;
    end else begin
      bit clr, go, inc, tap;
      int nd;
      logic [31:0] nc;
      clr = wr_en && (wr_addr == 2'd0);
      go  = tick_en && !osc_off;
      inc = go && (m_div == DIV_TOP - 1) && !clr;
      nd  = clr ? 0 : (go ? (m_div + 1) % DIV_TOP : m_div);
      nc  = m_cnt + (inc ? 32'd1 : 32'd0);
      if (wr_en) nc[wr_addr*8 +: 8] = wr_data;
      case (rate_sel)
        2'd0:    tap = ((m_div >> 14) & 1) != 0;
        2'd1:    tap = ((m_div >> 2) & 1) != 0;
        2'd2:    tap = ((m_div >> 1) & 1) != 0;
        default: tap = tick_en;
      endcase
      if (snap) m_rd = m_cnt;
      m_sqw  = !osc_off && tap;
      m_flag = (osc_off || stop_det) ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
      m_div  = nd;
      m_cnt  = nc;
    end
  end

  always @(negedge clk) begin
    if (run && !done) begin
      checks += 3;
      if (rd_value !== m_rd) begin
        errors++;
        $display("FAIL R6 model rd_value act %h exp %h", rd_value, m_rd);
      end
      if (sqw !== m_sqw) begin
        errors++;
        $display("FAIL R7 model sqw act %b exp %b", sqw, m_sqw);
      end
      if (stop_flag !== m_flag) begin
        errors++;
        $display("FAIL R9 model stop_flag act %b exp %b", stop_flag, m_flag);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic take_snap();
    snap = 1'b1;
    @(negedge clk);
    snap = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act expired exp finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;

    // R1 reset state
    chk("R1 rd_value", rd_value, 32'h0);
    chk("R1 sqw", {31'b0, sqw}, 32'h0);
    chk("R1 stop_flag", {31'b0, stop_flag}, 32'h1);

    // R9 clear by software
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R9 cleared", {31'b0, stop_flag}, 32'h0);

    // R4 load all four bytes, byte k at address k
    wr_byte(2'd3, 8'h12); wr_byte(2'd2, 8'h34);
    wr_byte(2'd1, 8'h56); wr_byte(2'd0, 8'h78);
    take_snap();
    chk("R4 full load", rd_value, 32'h12345678);
    wr_byte(2'd2, 8'hAB);
    take_snap();
    chk("R4 single lane", rd_value, 32'h12AB5678);

    // R2 one second is 32768 ticks after the last clear
    ticks(DIV_TOP - 1);
    take_snap();
    chk("R2 before wrap", rd_value, 32'h12AB5678);
    ticks(1);
    take_snap();
    chk("R2 after wrap", rd_value, 32'h12AB5679);

    // R6 held while counting continues
    ticks(100);
    chk("R6 held", rd_value, 32'h12AB5679);

    // R5 byte-0 write clears the prescaler
    ticks(1000);
    wr_byte(2'd0, 8'h00);
    ticks(DIV_TOP - 1);
    take_snap();
    chk("R5 no early step", rd_value, 32'h12AB5600);
    ticks(1);
    take_snap();
    chk("R5 step after full count", rd_value, 32'h12AB5601);

    // R7 rate taps after a prescaler clear
    rate_sel = 2'b01;
    wr_byte(2'd0, 8'h01);
    ticks(4);
    chk("R7 4k low", {31'b0, sqw}, 32'h0);
    ticks(1);
    chk("R7 4k high", {31'b0, sqw}, 32'h1);
    rate_sel = 2'b10;
    ticks(1);
    chk("R7 8k low", {31'b0, sqw}, 32'h0);
    ticks(1);
    chk("R7 8k high", {31'b0, sqw}, 32'h1);
    rate_sel = 2'b11;
    ticks(1);
    chk("R7 base high", {31'b0, sqw}, 32'h1);
    @(negedge clk);
    chk("R7 base low", {31'b0, sqw}, 32'h0);

    // R3 R8 R9 oscillator disabled
    take_snap();
    chk("R3 before stop", rd_value, 32'h12AB5601);
    osc_off = 1'b1;
    ticks(1000);
    chk("R8 sqw low", {31'b0, sqw}, 32'h0);
    chk("R9 set by osc_off", {31'b0, stop_flag}, 32'h1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R9 set wins", {31'b0, stop_flag}, 32'h1);
    take_snap();
    chk("R3 frozen", rd_value, 32'h12AB5601);
    osc_off = 1'b0;
    @(negedge clk);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R9 cleared after", {31'b0, stop_flag}, 32'h0);
    stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
    chk("R9 stop_det", {31'b0, stop_flag}, 32'h1);
    @(negedge clk);
    chk("R9 sticky", {31'b0, stop_flag}, 32'h1);

    // R10 wrap of the full count
    rate_sel = 2'b00;
    wr_byte(2'd3, 8'hFF); wr_byte(2'd2, 8'hFF);
    wr_byte(2'd1, 8'hFF); wr_byte(2'd0, 8'hFF);
    ticks(DIV_TOP);
    take_snap();
    chk("R10 wrap", rd_value, 32'h0);

    @(negedge clk);
    finish_run();
  end
endmodule